// File: doc/BRIEF.md
# Flash Bulk-Erase Sequencer

This block is a host-side controller for a byte-wide flash memory that uses a command register. One `start` pulse runs the whole bulk-erase procedure on the memory's command bus. The procedure has four phases:

1. Every byte is programmed to 00h, one address after another.
2. The chip is erased with two back-to-back erase commands (20h), and the controller times the erase window.
3. Each byte is checked in turn. For each address the controller writes a verify command (A0h) with that address, then reads the byte back.
4. When every address has read back as FFh, the controller writes a closing command (00h by default) to leave verify mode and reports done.

A byte that does not read back FFh causes another full-chip erase. Checking then resumes at the address that failed, not at address 0. A parameter caps the number of these re-erase passes. When a further pass would exceed the cap, the controller raises `fail` and stops.

Bus timing is counted in clocks. A write cycle drives address and data with chip enable low, holds write enable low for `WE_PULSE` clocks, then releases it for one clock. A read holds chip enable and output enable low for `READ_WAIT` clocks and samples data on the last of them. The program time and the erase time are parameters in clocks. The block has no data stream, so every pin is a plain level. `start` is a one-cycle request that needs no handshake.

Top module: `flerase_ctrl`

## Requirements
- R1: After reset, busy, done and fail are 0 and retry_count is 0. The bus is idle: fl_ce_n, fl_we_n and fl_oe_n are all 1.
- R2: A start pulse while idle, done or failed raises busy on the next clock and clears done and fail.
- R3: Before the first erase command of a run, every address is programmed to 00h. Each byte is programmed by writing 40h, then writing 00h to that address, then waiting PROG_CLKS clocks.
- R4: An erase consists of two consecutive bus writes of 20h. At least ERASE_CLKS clocks pass from the rising write-enable edge of the second write to the next write, which ends the erase.
- R5: Each address is verified by writing A0h with that address, then reading it back. A readback of FFh passes the byte. Addresses are verified in ascending order.
- R6: A byte that does not read back FFh causes a re-erase (two 20h writes) and increments retry_count. Verification then resumes at that same address.
- R7: If a byte fails while retry_count equals MAX_RETRY, fail is raised and no further bus cycle is issued.
- R8: After the last address passes, the controller writes EXIT_CMD (default 00h) once and then raises done.
- R9: done and fail are never both 1. Each is held until the next start. busy is 0 whenever either of them is 1.
- R10: In every write cycle fl_we_n is low for exactly WE_PULSE clocks, with fl_ce_n low and fl_data_oe high. In every read, fl_oe_n is low for exactly READ_WAIT clocks. fl_we_n and fl_oe_n are never low together.
- R11: A start pulse while busy has no effect on the sequence that is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a bulk erase |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Erase completed and verified |
| fail | output | 1 | Re-erase limit reached |
| retry_count | output | RW | Number of re-erase passes so far |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_data_oe | output | 1 | Controller drives the flash data bus |
| fl_rdata | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
Several rules are checked by assertions on every cycle:
- done and fail exclude each other.
- done and fail hold until the next start, and busy is low while either is set.
- retry_count stays within its bound and never steps by more than one.
- A bus request stays raised until it is acknowledged.
- Write enable and output enable are never low together.

The erase order can only be shown by the bench's flash model, across whole runs with bytes that need several erases. That order covers:
- pre-programming to 00h before the first erase,
- the two consecutive 20h writes and the length of the erase window,
- resuming at the failing address, which the bench sees as an exact count of verify commands,
- the closing command,
- the stop with no further bus traffic when the retry limit is exceeded.

// File: rtl/flerase_pkg.sv
package flerase_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_PP_SETUP,
    PH_PP_DATA,
    PH_PP_WAIT,
    PH_ER_SETUP,
    PH_ER_GO,
    PH_ER_WAIT,
    PH_EV_CMD,
    PH_EV_READ,
    PH_EXIT,
    PH_DONE,
    PH_FAIL
  } phase_e;

  typedef enum logic [2:0] {
    BUS_IDLE,
    BUS_SETUP,
    BUS_PULSE,
    BUS_HOLD,
    BUS_READ
  } bus_e;

  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_VERIFY  = 8'hA0;
  localparam logic [7:0] BYTE_ZERO   = 8'h00;
  localparam logic [7:0] BYTE_ERASED = 8'hFF;

endpackage

// File: rtl/flerase_timer.sv
module flerase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/flerase_bus.sv
module flerase_bus
  import flerase_pkg::*;
#(
  parameter int AW        = 15,
  parameter int WE_PULSE  = 4,
  parameter int READ_WAIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          ack,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  output logic          fl_data_oe,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);

  localparam int MAXP = (WE_PULSE > READ_WAIT) ? WE_PULSE : READ_WAIT;
  localparam int CW   = $clog2(MAXP + 1);

  bus_e          st_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BUS_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      unique case (st_q)
        BUS_IDLE: if (req) begin
          addr_q <= req_addr;
          data_q <= req_data;
          if (req_wr) begin
            st_q  <= BUS_SETUP;
            cnt_q <= CW'(WE_PULSE - 1);
          end else begin
            st_q  <= BUS_READ;
            cnt_q <= CW'(READ_WAIT - 1);
          end
        end
        BUS_SETUP: st_q <= BUS_PULSE;
        BUS_PULSE: begin
          if (cnt_q == '0) st_q <= BUS_HOLD;
          else             cnt_q <= cnt_q - 1'b1;
        end
        BUS_HOLD: st_q <= BUS_IDLE;
        BUS_READ: begin
          if (cnt_q == '0) st_q <= BUS_IDLE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= BUS_IDLE;
      endcase
    end
  end

  assign ack        = (st_q == BUS_HOLD) || ((st_q == BUS_READ) && (cnt_q == '0));
  assign fl_addr    = addr_q;
  assign fl_wdata   = data_q;
  assign fl_ce_n    = (st_q == BUS_IDLE);
  assign fl_we_n    = (st_q != BUS_PULSE);
  assign fl_oe_n    = (st_q != BUS_READ);
  assign fl_data_oe = (st_q == BUS_SETUP) || (st_q == BUS_PULSE) || (st_q == BUS_HOLD);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);

  // R10
  no_bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));

  // R10
  we_rise_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (!fl_ce_n && fl_data_oe));

endmodule

// File: rtl/flerase_seq.sv
module flerase_seq
  import flerase_pkg::*;
#(
  parameter int         AW         = 15,
  parameter int         ERASE_CLKS = 500000,
  parameter int         PROG_CLKS  = 500,
  parameter int         MAX_RETRY  = 1000,
  parameter logic [7:0] EXIT_CMD   = 8'h00,
  parameter int         RW         = 10,
  parameter int         TW         = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ack,
  input  logic [7:0]    rd_byte,
  input  logic          texpired,
  output logic          req,
  output logic          req_wr,
  output logic [AW-1:0] req_addr,
  output logic [7:0]    req_data,
  output logic          tload,
  output logic [TW-1:0] tval,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [RW-1:0] retry_count
);

  localparam logic [AW-1:0] LAST_ADDR = '1;

  phase_e        ph_q;
  logic [AW-1:0] addr_q;
  logic [RW-1:0] retry_q;
  logic          done_q;
  logic          fail_q;
  logic          idle_like;

  assign idle_like = (ph_q == PH_IDLE) || (ph_q == PH_DONE) || (ph_q == PH_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      addr_q  <= '0;
      retry_q <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else if (idle_like) begin
      if (start) begin
        ph_q    <= PH_PP_SETUP;
        addr_q  <= '0;
        retry_q <= '0;
        done_q  <= 1'b0;
        fail_q  <= 1'b0;
      end
    end else begin
      unique case (ph_q)
        PH_PP_SETUP: if (ack) ph_q <= PH_PP_DATA;
        PH_PP_DATA:  if (ack) ph_q <= PH_PP_WAIT;
        PH_PP_WAIT:  if (texpired) begin
          if (addr_q == LAST_ADDR) begin
            addr_q <= '0;
            ph_q   <= PH_ER_SETUP;
          end else begin
            addr_q <= addr_q + 1'b1;
            ph_q   <= PH_PP_SETUP;
          end
        end
        PH_ER_SETUP: if (ack) ph_q <= PH_ER_GO;
        PH_ER_GO:    if (ack) ph_q <= PH_ER_WAIT;
        PH_ER_WAIT:  if (texpired) ph_q <= PH_EV_CMD;
        PH_EV_CMD:   if (ack) ph_q <= PH_EV_READ;
        PH_EV_READ:  if (ack) begin
          if (rd_byte == BYTE_ERASED) begin
            if (addr_q == LAST_ADDR) ph_q <= PH_EXIT;
            else begin
              addr_q <= addr_q + 1'b1;
              ph_q   <= PH_EV_CMD;
            end
          end else if (retry_q == RW'(MAX_RETRY)) begin
            fail_q <= 1'b1;
            ph_q   <= PH_FAIL;
          end else begin
            retry_q <= retry_q + 1'b1;
            ph_q    <= PH_ER_SETUP;
          end
        end
        PH_EXIT: if (ack) begin
          done_q <= 1'b1;
          ph_q   <= PH_DONE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    req      = 1'b1;
    req_wr   = 1'b1;
    req_data = BYTE_ZERO;
    unique case (ph_q)
      PH_PP_SETUP: req_data = CMD_PROG;
      PH_PP_DATA:  req_data = BYTE_ZERO;
      PH_ER_SETUP,
      PH_ER_GO:    req_data = CMD_ERASE;
      PH_EV_CMD:   req_data = CMD_VERIFY;
      PH_EV_READ:  req_wr   = 1'b0;
      PH_EXIT:     req_data = EXIT_CMD;
      default:     req      = 1'b0;
    endcase
  end

  assign req_addr    = addr_q;
  assign tload       = ack && ((ph_q == PH_PP_DATA) || (ph_q == PH_ER_GO));
  assign tval        = (ph_q == PH_ER_GO) ? TW'(ERASE_CLKS) : TW'(PROG_CLKS);
  assign busy        = !idle_like;
  assign done        = done_q;
  assign fail        = fail_q;
  assign retry_count = retry_q;

  // R9
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R9
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !busy);

  // R7
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_count <= RW'(MAX_RETRY));

  // R6
  retry_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((retry_count == $past(retry_count)) || (retry_count == $past(retry_count) + 1'b1)));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R7
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !req);

endmodule

// File: rtl/flerase_ctrl.sv
module flerase_ctrl
  import flerase_pkg::*;
#(
  parameter int         ADDR_W     = 15,
  parameter int         WE_PULSE   = 4,
  parameter int         READ_WAIT  = 3,
  parameter int         ERASE_CLKS = 500000,
  parameter int         PROG_CLKS  = 500,
  parameter int         MAX_RETRY  = 1000,
  parameter logic [7:0] EXIT_CMD   = 8'h00,
  localparam int        RW         = $clog2(MAX_RETRY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [RW-1:0]     retry_count,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_wdata,
  output logic              fl_data_oe,
  input  logic [7:0]        fl_rdata,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n
);

  localparam int TMAX = (ERASE_CLKS > PROG_CLKS) ? ERASE_CLKS : PROG_CLKS;
  localparam int TW   = $clog2(TMAX + 1);

  logic              req;
  logic              req_wr;
  logic [ADDR_W-1:0] req_addr;
  logic [7:0]        req_data;
  logic              ack;
  logic              tload;
  logic [TW-1:0]     tval;
  logic              texpired;

  flerase_seq #(
    .AW(ADDR_W), .ERASE_CLKS(ERASE_CLKS), .PROG_CLKS(PROG_CLKS),
    .MAX_RETRY(MAX_RETRY), .EXIT_CMD(EXIT_CMD), .RW(RW), .TW(TW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ack(ack), .rd_byte(fl_rdata),
    .texpired(texpired), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_data(req_data), .tload(tload), .tval(tval), .busy(busy),
    .done(done), .fail(fail), .retry_count(retry_count)
  );

  flerase_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tload), .load_val(tval), .expired(texpired)
  );

  flerase_bus #(
    .AW(ADDR_W), .WE_PULSE(WE_PULSE), .READ_WAIT(READ_WAIT)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_data(req_data), .ack(ack), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_data_oe(fl_data_oe), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

endmodule

// File: tb/test_flerase_ctrl.sv
module test_flerase_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 3;
  localparam int NB         = 1 << AW;
  localparam int WE_PULSE   = 2;
  localparam int READ_WAIT  = 2;
  localparam int ERASE_CLKS = 20;
  localparam int PROG_CLKS  = 3;
  localparam int MAX_RETRY  = 2;
  localparam int RW         = $clog2(MAX_RETRY + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, fail;
  logic [RW-1:0] retry_count;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata;
  logic          fl_data_oe;
  logic [7:0]    fl_rdata;
  logic          fl_ce_n, fl_we_n, fl_oe_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flerase_ctrl #(
    .ADDR_W(AW), .WE_PULSE(WE_PULSE), .READ_WAIT(READ_WAIT),
    .ERASE_CLKS(ERASE_CLKS), .PROG_CLKS(PROG_CLKS), .MAX_RETRY(MAX_RETRY)
  ) i_flerase_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .retry_count(retry_count), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_data_oe(fl_data_oe), .fl_rdata(fl_rdata),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  // ---------------- flash model ----------------
  logic [7:0] mem [NB];
  int  hard [NB];
  int  ecnt, cyc_n, er_start, we_len, oe_len;
  bit  pend_prog, er_setup, er_active, vmode, first_erase, we_prev, oe_prev;
  logic [AW-1:0] vaddr;
  int  n_writes, n_reads, n_prog, n_erase, n_verify, n_other, last_v;
  int  viol_bus, viol_pre, viol_pulse, viol_order;
  logic [7:0] last_other;

  always_comb fl_rdata = vmode ? mem[vaddr] : mem[fl_addr];

  task automatic model_write(input logic [AW-1:0] a, input logic [7:0] d);
    if (er_active) begin
      if (cyc_n - er_start < ERASE_CLKS) viol_pulse++;
      er_active = 0;
      ecnt++;
      for (int i = 0; i < NB; i++) if (ecnt >= hard[i]) mem[i] = 8'hFF;
    end
    if (pend_prog) begin
      mem[a] = mem[a] & d;
      pend_prog = 0;
      n_prog++;
    end else if (d == 8'h40) begin
      pend_prog = 1; vmode = 0; er_setup = 0;
    end else if (d == 8'h20) begin
      vmode = 0;
      if (er_setup) begin
        er_setup = 0; er_active = 1; er_start = cyc_n; n_erase++;
        if (first_erase) begin
          for (int i = 0; i < NB; i++) if (mem[i] != 8'h00) viol_pre++;
          first_erase = 0;
        end
      end else er_setup = 1;
    end else if (d == 8'hA0) begin
      er_setup = 0; vmode = 1; vaddr = a; n_verify++;
      if (int'(a) < last_v) viol_order++;
      last_v = int'(a);
    end else begin
      er_setup = 0; vmode = 0; n_other++; last_other = d;
    end
  endtask

  always @(negedge clk) begin
    cyc_n++;
    if (!fl_we_n) we_len++;
    else if (!we_prev) begin
      if (we_len != WE_PULSE || fl_ce_n || !fl_data_oe) viol_bus++;
      we_len = 0;
      n_writes++;
      model_write(fl_addr, fl_wdata);
    end
    if (!fl_oe_n) begin
      oe_len++;
      if (!fl_we_n || fl_ce_n) viol_bus++;
    end else if (!oe_prev) begin
      if (oe_len != READ_WAIT) viol_bus++;
      oe_len = 0;
      n_reads++;
    end
    we_prev = fl_we_n;
    oe_prev = fl_oe_n;
  end

  // ---------------- checking ----------------
  int errors = 0;
  int checks = 0;
  int plan_h [NB];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int max_hard();
    int m = 1;
    for (int i = 0; i < NB; i++) if (plan_h[i] > m) m = plan_h[i];
    return m;
  endfunction

  task automatic run_case(input bit poke);
    int need, wr_snap, t;
    bit ok_ff;
    for (int i = 0; i < NB; i++) begin
      mem[i]  = 8'($urandom_range(1, 255));
      hard[i] = plan_h[i];
    end
    ecnt = 0; pend_prog = 0; er_setup = 0; er_active = 0; vmode = 0;
    first_erase = 1; last_v = 0;
    n_writes = 0; n_reads = 0; n_prog = 0; n_erase = 0; n_verify = 0; n_other = 0;
    viol_bus = 0; viol_pre = 0; viol_pulse = 0; viol_order = 0; last_other = 8'hEE;
    need = max_hard() - 1;

    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy && !done && !fail, "R2 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;   // R11: must be ignored
    end
    t = 0;
    while (!(done || fail) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(t < 20000, "watchdog", t, 20000);
    repeat (3) @(negedge clk);
    wr_snap = n_writes;
    repeat (20) @(negedge clk);

    check(viol_bus == 0, "R10 bus timing", viol_bus, 0);
    check(viol_pre == 0 && n_prog == NB, "R3 preprogram", n_prog, NB);
    check(viol_pulse == 0, "R4 erase window", viol_pulse, 0);
    check(viol_order == 0, "R5 verify order", viol_order, 0);
    check(!(done && fail) && !busy, "R9 exclusive and idle", int'(busy), 0);
    check(n_writes == wr_snap, "R9 no traffic after end", n_writes, wr_snap);
    if (poke) check(n_prog == NB, "R11 start ignored", n_prog, NB);
    if (need <= MAX_RETRY) begin
      ok_ff = 1;
      for (int i = 0; i < NB; i++) if (mem[i] != 8'hFF) ok_ff = 0;
      check(done && !fail, "R8 done", int'(done), 1);
      check(int'(retry_count) == need, "R6 retries", int'(retry_count), need);
      check(n_erase == need + 1, "R4 erase count", n_erase, need + 1);
      check(n_verify == NB + need, "R6 resume verify count", n_verify, NB + need);
      check(n_reads == NB + need, "R5 reads", n_reads, NB + need);
      check(n_other == 1 && last_other == 8'h00, "R8 exit command", int'(last_other), 0);
      check(ok_ff, "R5 all erased", int'(ok_ff), 1);
    end else begin
      check(fail && !done, "R7 fail", int'(fail), 1);
      check(int'(retry_count) == MAX_RETRY, "R7 retries", int'(retry_count), MAX_RETRY);
      check(n_erase == MAX_RETRY + 1, "R7 erase count", n_erase, MAX_RETRY + 1);
      check(n_other == 0, "R7 no exit", n_other, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    cyc_n = 0; we_len = 0; oe_len = 0; we_prev = 1; oe_prev = 1;
    for (int i = 0; i < NB; i++) begin mem[i] = 8'hFF; hard[i] = 1; end
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && retry_count == '0, "R1 status reset", int'(busy), 0);
    check(fl_ce_n && fl_we_n && fl_oe_n, "R1 bus idle", int'(fl_ce_n), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NB; i++) plan_h[i] = 1;
    run_case(0);                                  // clean erase
    for (int i = 0; i < NB; i++) plan_h[i] = 1;
    plan_h[NB-1] = 3;
    run_case(1);                                  // retry limit reached exactly, start poke
    for (int i = 0; i < NB; i++) plan_h[i] = 1;
    plan_h[0] = 2; plan_h[5] = 3;
    run_case(0);                                  // resume at two different addresses
    for (int i = 0; i < NB; i++) plan_h[i] = 1;
    plan_h[3] = 4;
    run_case(0);                                  // over the limit -> fail
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < NB; i++)
        plan_h[i] = ($urandom_range(0, 9) < 7) ? 1 : int'($urandom_range(2, 4));
      run_case(r[0]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule